// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of one read or write burst inside a synchronous DRAM. A one-cycle start strobe loads a 9-bit start column together with a burst-length code and an ordering type. From the next cycle on, the block puts out one column per clock with a valid flag until the burst ends.

A burst ends when its beat count runs out, when a terminate input stops it, or when a new start replaces it. Length codes 0 to 3 give 1, 2, 4 or 8 beats. Code 7 selects a full page, which walks through all 512 columns and runs until it is stopped.

Sequential ordering counts the low bits of the column upward and wraps them within the burst length. Interleaved ordering XORs the start column's low bits with the beat index. A full page with interleaved ordering, or a reserved length code, is an illegal mode. For these the block runs a substitute burst and raises an error flag.

The state machine has three states:
- `ST_IDLE`: no burst is running.
- `ST_BURST`: a finite burst is running.
- `ST_PAGE`: a sequential full-page burst is running.

Its transitions are:
- launch (`ST_IDLE` to `ST_BURST` or `ST_PAGE`, on start).
- relaunch (any state to `ST_BURST` or `ST_PAGE`, on start while a burst runs).
- complete (`ST_BURST` to `ST_IDLE`, after the last beat).
- stop (`ST_BURST` or `ST_PAGE` to `ST_IDLE`, on terminate).

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, `valid`, `col` and `mode_err` are all 0.
- R2: A start captures `start_col`, `blen` and `btype`. In the following cycle `valid` is 1 and `col` equals the captured start column. One beat follows per cycle after that, and changes of `blen`/`btype` during a burst have no effect on it.
- R3: Sequential ordering (`btype`=0) with `blen` code 0, 1, 2 or 3 gives N = 1, 2, 4 or 8 beats. On beat i, the low log2(N) bits of `col` equal (start + i) mod N, and the upper bits stay equal to those of the start column.
- R4: Interleaved ordering (`btype`=1) with `blen` code 0 to 3 gives N beats. On beat i, the low log2(N) bits of `col` equal the start's low bits XOR i, and the upper bits are unchanged.
- R5: A finite burst of N beats has `valid` high for exactly N consecutive cycles, and `valid` is 0 in the cycle after the last beat.
- R6: With `btype`=0 and `blen`=7, `col` rises by one each cycle modulo 512, so 511 is followed by 0. The burst continues without limit until it is terminated or restarted.
- R7: `term` high with `start` low during a burst makes `valid` 0 in the next cycle. The beat shown in the cycle where `term` is high is the final beat.
- R8: A start during a running burst restarts the sequence in the next cycle from the new start column with the new configuration. When `start` and `term` are high together, the start wins.
- R9: A start with `btype`=1 and `blen`=7 runs an 8-beat interleaved burst and sets `mode_err` to 1 from the first beat.
- R10: `blen` codes 4, 5 and 6 are reserved. A start with one of them runs a single beat at the start column and sets `mode_err` to 1.
- R11: `mode_err` is updated only at a start: it becomes 1 for an illegal mode and 0 for a legal one. It holds its value through the burst and while idle.
- R12: Whenever `valid` is 0, `col` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | New burst command strobe |
| start_col | input | 9 | First column of the burst |
| blen | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 7 gives a full page, 4..6 are reserved |
| btype | input | 1 | 0 selects sequential ordering, 1 selects interleaved ordering |
| term | input | 1 | Burst terminate |
| col | output | 9 | Column of the current beat |
| valid | output | 1 | A beat is present this cycle |
| mode_err | output | 1 | The last start requested an illegal mode |

## Verification
Every start column from 0 to 511 is run with every finite length code in both orderings:
- Starts near the top of each aligned block tell the in-block wrap apart from a carry into the upper bits.
- Comparing the two orderings on the same start separates addition from XOR.

Full-page runs are tried in two ways:
- Runs starting just below 511 expose the page wrap.
- A run longer than 512 beats shows that no count limit ends the burst.

Terminate and restart are applied in the middle of both finite and full-page bursts, including the case where both arrive in the same cycle. Reserved codes and the interleaved full-page request are each followed by a legal start, to show the error flag being set, held and cleared.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bst_e;

    localparam int          BLEN_W         = 3;
    localparam logic [2:0]  BL_LAST_FINITE = 3'd3;
    localparam logic [2:0]  BL_PAGE        = 3'd7;
    localparam int          ITL_SUB_LOG2   = 3;

endpackage

// File: rtl/burst_cfg_dec.sv
module burst_cfg_dec
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [BLEN_W-1:0] blen,
    input  logic              btype,
    output logic [COL_W-1:0]  mask,
    output logic              page,
    output logic              err
);

    localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

    always_comb begin
        mask = '0;
        page = 1'b0;
        err  = 1'b0;
        if (blen <= BL_LAST_FINITE) begin
            mask = ~(ONES << blen);
        end else if (blen == BL_PAGE) begin
            if (btype) begin
                // interleaved full page is not allowed: substitute 8 beats
                mask = ~(ONES << ITL_SUB_LOG2);
                err  = 1'b1;
            end else begin
                mask = ONES;
                page = 1'b1;
            end
        end else begin
            // reserved length code: single beat
            err = 1'b1;
        end
    end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             itl,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;

    assign sum = base + cnt;

    for (genvar g = 0; g < COL_W; g++) begin : g_bit
        always_comb begin
            if (!mask[g])
                col[g] = base[g];
            else if (itl)
                col[g] = base[g] ^ cnt[g];
            else
                col[g] = sum[g];
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [BLEN_W-1:0] blen,
    input  logic              btype,
    input  logic              term,
    output logic [COL_W-1:0]  col,
    output logic              valid,
    output logic              mode_err
);

    bst_e             state_q, state_d;
    logic [COL_W-1:0] base_q, cnt_q, mask_q;
    logic             itl_q, err_q;
    logic [COL_W-1:0] dec_mask, map_col;
    logic             dec_page, dec_err;
    logic             last_beat, page_run;
    bst_e             launch_st;

    burst_cfg_dec #(.COL_W(COL_W)) u_dec (
        .blen (blen),
        .btype(btype),
        .mask (dec_mask),
        .page (dec_page),
        .err  (dec_err)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base(base_q),
        .cnt (cnt_q),
        .mask(mask_q),
        .itl (itl_q),
        .col (map_col)
    );

    assign last_beat = (cnt_q == mask_q);
    assign launch_st = dec_page ? ST_PAGE : ST_BURST;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = launch_st;
            end
            ST_BURST: begin
                if (start)                  state_d = launch_st;
                else if (term || last_beat) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (start)     state_d = launch_st;
                else if (term) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured configuration and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
            itl_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            cnt_q  <= '0;
            mask_q <= dec_mask;
            itl_q  <= btype;
            err_q  <= dec_err;
        end else if (state_q != ST_IDLE) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        valid    = (state_q != ST_IDLE);
        page_run = (state_q == ST_PAGE);
        col      = valid ? map_col : '0;
        mode_err = err_q;
    end

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic [2:0]       blen,
    input logic             btype,
    input logic             term,
    input logic [COL_W-1:0] col,
    input logic             valid,
    input logic             mode_err,
    input logic [COL_W-1:0] mask_q,
    input logic             page_run
);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid && col == $past(start_col));                          // R2

    AST_TERM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        term && !start |=> !valid);                                           // R7

    AST_IDLE_COL: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> col == '0);                                                // R12

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        valid && $past(valid) && !$past(start)
        |-> ((col ^ $past(col)) & ~mask_q) == '0);                            // R3

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        page_run && !start && !term |=> col == COL_W'($past(col) + 1'b1));    // R6

    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        start && btype && blen == 3'd7 |=> mode_err && valid);                // R9

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(mode_err));                                        // R11

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_col(start_col),
    .blen     (blen),
    .btype    (btype),
    .term     (term),
    .col      (col),
    .valid    (valid),
    .mode_err (mode_err),
    .mask_q   (mask_q),
    .page_run (page_run)
);

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] blen = '0;
    logic       btype = 1'b0;
    logic       term = 1'b0;
    logic [8:0] col;
    logic       valid;
    logic       mode_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_col_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .blen(blen), .btype(btype), .term(term),
        .col(col), .valid(valid), .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(valid == 1'b0, req, valid, 0);
        chk(col == 9'd0, "R12", col, 0);
    endtask

    function automatic int exp_col(input int s, input int n, input bit bt, input int i);
        if (bt) return s ^ i;
        return (s & ~(n - 1)) | ((s + i) & (n - 1));
    endfunction

    // issue a start at the next falling edge; returns after the first beat is visible
    task automatic launch(input int s, input int code, input bit bt);
        @(negedge clk);
        start = 1'b1; start_col = 9'(s); blen = 3'(code); btype = bt;
        @(negedge clk);
        start = 1'b0;
    endtask

    // full finite burst with all beats checked; covers R2 R3 R4 R5 R9 R10 R11
    task automatic finite_burst(input int s, input int code, input bit bt);
        int  n;
        bit  e;
        string req;
        if (code <= 3)      begin n = 1 << code; e = 1'b0; end
        else if (code == 7) begin n = 8;         e = 1'b1; end
        else                begin n = 1;         e = 1'b1; end
        req = (code == 7) ? "R9" : (code > 3) ? "R10" : (bt ? "R4" : "R3");
        launch(s, code, bt);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            blen = 3'(i);           // changes mid-burst must be ignored (R2)
            chk(valid == 1'b1, "R5", valid, 1);
            chk(col == 9'(exp_col(s, n, bt, i)), req, col, exp_col(s, n, bt, i));
            chk(mode_err == e, "R11", mode_err, e);
        end
        @(negedge clk);
        chk_idle("R5");
        chk(mode_err == e, "R11", mode_err, e);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_idle("R1");
        chk(mode_err == 1'b0, "R1", mode_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle("R1");
        chk(mode_err == 1'b0, "R1", mode_err, 0);

        // R3 R4 R5: every start column, every finite length, both orderings
        for (int s = 0; s < 512; s++)
            for (int code = 0; code < 4; code++)
                for (int bt = 0; bt < 2; bt++)
                    finite_burst(s, code, bt[0]);

        // R9 and R11: illegal interleaved page, then a legal start clears the flag
        finite_burst(13, 7, 1'b1);
        repeat (3) @(negedge clk);
        chk(mode_err == 1'b1, "R11", mode_err, 1);
        finite_burst(13, 1, 1'b0);
        finite_burst(510, 7, 1'b1);

        // R10: reserved codes
        for (int code = 4; code < 7; code++) begin
            finite_burst(200 + code, code, 1'b0);
            finite_burst(77, code, 1'b1);
        end
        finite_burst(5, 2, 1'b1);

        // R6: full page across the wrap, more than one page long, then terminate (R7)
        launch(505, 7, 1'b0);
        for (int i = 0; i < 530; i++) begin
            if (i > 0) @(negedge clk);
            chk(valid == 1'b1 && col == 9'((505 + i) % 512), "R6", col, (505 + i) % 512);
        end
        chk(mode_err == 1'b0, "R11", mode_err, 0);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk_idle("R7");

        // R7: terminate in a finite burst after three beats
        launch(5, 3, 1'b0);
        @(negedge clk);
        chk(col == 9'd6, "R3", col, 6);
        @(negedge clk);
        chk(col == 9'd7, "R3", col, 7);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk_idle("R7");
        repeat (2) @(negedge clk);
        chk_idle("R7");

        // R8: restart a sequential burst with an interleaved one
        launch(16, 3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk(col == 9'd18, "R8", col, 18);
        start = 1'b1; start_col = 9'd301; blen = 3'd2; btype = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (i > 0) @(negedge clk);
            chk(valid == 1'b1 && col == 9'(301 ^ i), "R8", col, 301 ^ i);
        end
        @(negedge clk);
        chk_idle("R8");

        // R8: start and term together in a full page burst
        launch(100, 7, 1'b0);
        @(negedge clk);
        start = 1'b1; term = 1'b1; start_col = 9'd42; blen = 3'd1; btype = 1'b0;
        @(negedge clk);
        start = 1'b0; term = 1'b0;
        chk(valid == 1'b1 && col == 9'd42, "R8", col, 42);
        @(negedge clk);
        chk(valid == 1'b1 && col == 9'd43, "R8", col, 43);
        @(negedge clk);
        chk_idle("R5");

        // R7: term while idle has no effect
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk_idle("R7");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule